// File: doc/BRIEF.md
# Palette-Indexed Frame Streamer

This block pushes one full frame from a byte-per-pixel frame memory to an external display controller over a parallel write bus. Each stored byte selects an entry of an internal colour table, and the selected colour is the word placed on the bus. The display controller advances its own pixel address, so the block sends a single write-memory command word and then one data word per pixel, each marked by one pulse of an active-low write strobe.

Software loads the colour table through a small write port while the block is idle and then raises a one-cycle start request. The block waits for a rising edge on the controller's tearing-effect line, which marks vertical blanking, so that the update does not tear. Once the last pixel has gone out, the block can refill the frame memory with a fixed index so that drawing of the next frame starts from a clean background. A start request raised during that refill is held and served as soon as the refill ends.

Top module: `pal_frame_streamer`

## Requirements
- R1: A frame is one command word followed by H_PIX*V_PIX pixel words. Pixel k is read from frame-memory address k, in increasing order from 0. The memory returns read data in the cycle after `fm_rd_en`.
- R2: Each pixel word equals the colour-table entry selected by the pixel's index. The table has 2^IDX_W entries of COL_W bits. A host write (`pal_we`) while `busy` is low stores `pal_wdata` at `pal_addr`.
- R3: No write strobe is issued until a rising edge of `te` is seen after the start was accepted. A `te` edge that comes before the start has no effect.
- R4: The command word carries the value CMD_WORD with `bus_dc` low. Every pixel word has `bus_dc` high. `bus_data` and `bus_dc` do not change while `bus_wr_n` is low.
- R5: The `bus_data` register is reloaded only when the next word differs from the word already held. Within a frame, the number of changes on `bus_data` therefore equals the number of adjacent differences in the sequence (previous bus value, CMD_WORD, pixel colours).
- R6: Each strobe holds `bus_wr_n` low for exactly max(`strobe_len`,1) cycles. Between two words of one frame it stays high for max(`strobe_len`,1)+4 cycles.
- R7: A palette write while `busy` is high is discarded and raises `pal_drop` for one cycle, in the cycle after the write.
- R8: `busy` goes high in the cycle after a start is accepted and stays high until `done`. `done` lasts one cycle, comes after the last strobe has returned high, and `busy` is already low in that cycle.
- R9: With CLEAR_EN set, the cycles after `done` write FILL_IDX to every frame-memory address from 0 to H_PIX*V_PIX-1, one address per cycle.
- R10: A start raised during the clear sets `busy` at once. The new transfer waits for the clear to finish and then for a `te` edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle frame request |
| te | input | 1 | Tearing-effect (vertical blanking) line from the controller |
| strobe_len | input | LEN_W | Strobe low/high length in cycles (0 is treated as 1) |
| pal_we | input | 1 | Colour-table write enable |
| pal_addr | input | IDX_W | Colour-table write index |
| pal_wdata | input | COL_W | Colour-table write value |
| pal_drop | output | 1 | Pulse: a table write was discarded |
| fm_addr | output | ADDR_W | Frame-memory address |
| fm_rd_en | output | 1 | Frame-memory read request |
| fm_rdata | input | IDX_W | Frame-memory read data, one cycle after the request |
| fm_wr_en | output | 1 | Frame-memory write (clear) |
| fm_wdata | output | IDX_W | Frame-memory write data |
| bus_data | output | COL_W | Parallel bus data |
| bus_dc | output | 1 | Low for the command word, high for pixel data |
| bus_wr_n | output | 1 | Active-low write strobe |
| busy | output | 1 | Frame transfer in progress |
| done | output | 1 | One-cycle end-of-frame pulse |

## Verification
The strobe-length property assumes that `strobe_len` is held constant while `busy` is high. The bench therefore changes it only between frames, after `done`. The bench raises `start` for a single cycle, always between clock edges. It holds `te` high for several cycles at a time, so that the synchroniser sees a clean edge. The frame-memory model returns read data one cycle after a request, which matches the timing the lookup pipeline expects.

// File: rtl/pfs_pkg.sv
package pfs_pkg;
   typedef enum logic [3:0] {
      ST_IDLE,
      ST_SYNC,
      ST_CMD,
      ST_CMDS,
      ST_CMDW,
      ST_FETCH,
      ST_LOOK,
      ST_LOAD,
      ST_SEND,
      ST_PXW,
      ST_CLR
   } seq_state_t;
endpackage

// File: rtl/pfs_palette.sv
module pfs_palette #(
   parameter int IDX_W = 8,
   parameter int COL_W = 16
) (
   input  logic             clk,
   input  logic             we,
   input  logic [IDX_W-1:0] waddr,
   input  logic [COL_W-1:0] wdata,
   input  logic [IDX_W-1:0] raddr,
   output logic [COL_W-1:0] rdata
);
   localparam int DEPTH = 1 << IDX_W;

   logic [COL_W-1:0] table_q [DEPTH];

   // registered read: colour is valid the cycle after raddr
   always_ff @(posedge clk) begin
      if (we) table_q[waddr] <= wdata;
      rdata <= table_q[raddr];
   end
endmodule

// File: rtl/pfs_strobe.sv
module pfs_strobe #(
   parameter int LEN_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   input  logic [LEN_W-1:0] len,
   output logic             wr_n,
   output logic             fin
);
   logic             act_q;
   logic             low_q;
   logic [LEN_W-1:0] cnt_q;
   logic [LEN_W-1:0] eff_len;

   assign eff_len = (len == '0) ? LEN_W'(1) : len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q <= 1'b0;
         low_q <= 1'b0;
         cnt_q <= '0;
      end else if (!act_q) begin
         if (go) begin
            act_q <= 1'b1;
            low_q <= 1'b1;
            cnt_q <= eff_len - LEN_W'(1);
         end
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - LEN_W'(1);
      end else if (low_q) begin
         low_q <= 1'b0;
         cnt_q <= eff_len - LEN_W'(1);
      end else begin
         act_q <= 1'b0;
      end
   end

   assign wr_n = ~(act_q & low_q);
   assign fin  = act_q & ~low_q & (cnt_q == '0);
endmodule

// File: rtl/pfs_seq.sv
module pfs_seq
   import pfs_pkg::*;
#(
   parameter int          IDX_W          = 8,
   parameter int          COL_W          = 16,
   parameter int          ADDR_W         = 19,
   parameter int          NPIX           = 384000,
   parameter int          TE_SYNC_STAGES = 2,
   parameter bit          CLEAR_EN       = 1'b1,
   parameter logic [15:0] CMD_WORD       = 16'h002C
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              te,
   input  logic              stb_fin,
   input  logic [COL_W-1:0]  pal_rdata,
   output logic              stb_go,
   output logic [ADDR_W-1:0] pix_addr,
   output logic              rd_en,
   output logic              clr_en,
   output logic [COL_W-1:0]  data_q,
   output logic              dc_q,
   output logic              busy_q,
   output logic              done_q
);
   localparam logic [ADDR_W-1:0] LAST_PIX = ADDR_W'(NPIX - 1);

   seq_state_t       st_q;
   seq_state_t       after_frame;
   logic [ADDR_W-1:0] pix_q;
   logic [TE_SYNC_STAGES-1:0] te_pipe;
   logic             te_d;
   logic             te_edge;

   // tearing-effect synchroniser
   genvar gi;
   generate
      for (gi = 0; gi < TE_SYNC_STAGES; gi++) begin : g_te
         if (gi == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) te_pipe[0] <= 1'b0;
               else        te_pipe[0] <= te;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) te_pipe[gi] <= 1'b0;
               else        te_pipe[gi] <= te_pipe[gi-1];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) te_d <= 1'b0;
      else        te_d <= te_pipe[TE_SYNC_STAGES-1];

   assign te_edge = te_pipe[TE_SYNC_STAGES-1] & ~te_d;

   generate
      if (CLEAR_EN) begin : g_clear
         assign after_frame = ST_CLR;
      end else begin : g_noclear
         assign after_frame = ST_IDLE;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         pix_q  <= '0;
         busy_q <= 1'b0;
         done_q <= 1'b0;
         data_q <= '0;
         dc_q   <= 1'b1;
      end else begin
         done_q <= 1'b0;
         if (start && !busy_q) busy_q <= 1'b1;
         unique case (st_q)
            ST_IDLE:  if (busy_q || start) st_q <= ST_SYNC;
            ST_SYNC:  if (te_edge) st_q <= ST_CMD;
            ST_CMD: begin
               if (data_q != COL_W'(CMD_WORD)) data_q <= COL_W'(CMD_WORD);
               dc_q <= 1'b0;
               st_q <= ST_CMDS;
            end
            ST_CMDS:  st_q <= ST_CMDW;
            ST_CMDW: begin
               if (stb_fin) begin
                  pix_q <= '0;
                  st_q  <= ST_FETCH;
               end
            end
            ST_FETCH: st_q <= ST_LOOK;
            ST_LOOK:  st_q <= ST_LOAD;
            ST_LOAD: begin
               if (pal_rdata != data_q) data_q <= pal_rdata;
               dc_q <= 1'b1;
               st_q <= ST_SEND;
            end
            ST_SEND:  st_q <= ST_PXW;
            ST_PXW: begin
               if (stb_fin) begin
                  if (pix_q == LAST_PIX) begin
                     done_q <= 1'b1;
                     busy_q <= 1'b0;
                     pix_q  <= '0;
                     st_q   <= after_frame;
                  end else begin
                     pix_q <= pix_q + ADDR_W'(1);
                     st_q  <= ST_FETCH;
                  end
               end
            end
            ST_CLR: begin
               if (pix_q == LAST_PIX) begin
                  pix_q <= '0;
                  st_q  <= ST_IDLE;
               end else begin
                  pix_q <= pix_q + ADDR_W'(1);
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign stb_go   = (st_q == ST_CMDS) || (st_q == ST_SEND);
   assign rd_en    = (st_q == ST_FETCH);
   assign clr_en   = (st_q == ST_CLR);
   assign pix_addr = pix_q;
endmodule

// File: rtl/pal_frame_streamer.sv
module pal_frame_streamer #(
   parameter int          H_PIX          = 800,
   parameter int          V_PIX          = 480,
   parameter int          IDX_W          = 8,
   parameter int          COL_W          = 16,
   parameter int          LEN_W          = 4,
   parameter int          TE_SYNC_STAGES = 2,
   parameter bit          CLEAR_EN       = 1'b1,
   parameter logic [7:0]  FILL_IDX       = 8'h00,
   parameter logic [15:0] CMD_WORD       = 16'h002C,
   localparam int         NPIX           = H_PIX * V_PIX,
   localparam int         ADDR_W         = (NPIX > 1) ? $clog2(NPIX) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              te,
   input  logic [LEN_W-1:0]  strobe_len,
   input  logic              pal_we,
   input  logic [IDX_W-1:0]  pal_addr,
   input  logic [COL_W-1:0]  pal_wdata,
   output logic              pal_drop,
   output logic [ADDR_W-1:0] fm_addr,
   output logic              fm_rd_en,
   input  logic [IDX_W-1:0]  fm_rdata,
   output logic              fm_wr_en,
   output logic [IDX_W-1:0]  fm_wdata,
   output logic [COL_W-1:0]  bus_data,
   output logic              bus_dc,
   output logic              bus_wr_n,
   output logic              busy,
   output logic              done
);
   generate
      if (H_PIX < 1 || V_PIX < 1) begin : g_bad_geom
         $error("frame must have at least one pixel");
      end
      if (IDX_W < 1 || IDX_W > 10) begin : g_bad_idx
         $error("IDX_W out of range 1..10");
      end
      if (COL_W < 1 || LEN_W < 1) begin : g_bad_w
         $error("COL_W and LEN_W must be positive");
      end
      if (TE_SYNC_STAGES < 1) begin : g_bad_sync
         $error("TE_SYNC_STAGES must be at least 1");
      end
   endgenerate

   logic             stb_go;
   logic             stb_fin;
   logic [COL_W-1:0] pal_rdata;
   logic             pal_wr_ok;
   logic             drop_q;

   assign pal_wr_ok = pal_we & ~busy;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) drop_q <= 1'b0;
      else        drop_q <= pal_we & busy;

   assign pal_drop = drop_q;

   pfs_palette #(.IDX_W(IDX_W), .COL_W(COL_W)) u_pal (
      .clk   (clk),
      .we    (pal_wr_ok),
      .waddr (pal_addr),
      .wdata (pal_wdata),
      .raddr (fm_rdata),
      .rdata (pal_rdata)
   );

   pfs_strobe #(.LEN_W(LEN_W)) u_stb (
      .clk   (clk),
      .rst_n (rst_n),
      .go    (stb_go),
      .len   (strobe_len),
      .wr_n  (bus_wr_n),
      .fin   (stb_fin)
   );

   pfs_seq #(
      .IDX_W(IDX_W), .COL_W(COL_W), .ADDR_W(ADDR_W), .NPIX(NPIX),
      .TE_SYNC_STAGES(TE_SYNC_STAGES), .CLEAR_EN(CLEAR_EN), .CMD_WORD(CMD_WORD)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .te        (te),
      .stb_fin   (stb_fin),
      .pal_rdata (pal_rdata),
      .stb_go    (stb_go),
      .pix_addr  (fm_addr),
      .rd_en     (fm_rd_en),
      .clr_en    (fm_wr_en),
      .data_q    (bus_data),
      .dc_q      (bus_dc),
      .busy_q    (busy),
      .done_q    (done)
   );

   assign fm_wdata = IDX_W'(FILL_IDX);
endmodule

// File: rtl/pfs_checker.sv
module pfs_checker #(
   parameter int COL_W = 16,
   parameter int LEN_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic [LEN_W-1:0] strobe_len,
   input logic             pal_we,
   input logic             pal_drop,
   input logic             fm_rd_en,
   input logic             fm_wr_en,
   input logic [COL_W-1:0] bus_data,
   input logic             bus_dc,
   input logic             bus_wr_n,
   input logic             busy,
   input logic             done
);
   logic           prev_wr;
   logic [LEN_W:0] low_cnt;
   logic [LEN_W:0] eff_len;

   assign eff_len = (strobe_len == '0) ? (LEN_W+1)'(1) : {1'b0, strobe_len};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_wr <= 1'b1;
         low_cnt <= '0;
      end else begin
         prev_wr <= bus_wr_n;
         low_cnt <= bus_wr_n ? '0 : low_cnt + (LEN_W+1)'(1);
      end
   end

   AST_DATA_HELD:  assert property (@(posedge clk) disable iff (!rst_n)
                      !bus_wr_n |=> (bus_wr_n || $stable(bus_data))); // R4
   AST_DC_HELD:    assert property (@(posedge clk) disable iff (!rst_n)
                      !bus_wr_n |=> (bus_wr_n || $stable(bus_dc)));   // R4
   AST_FALL_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
                      $fell(bus_wr_n) |-> $stable(bus_data));         // R5
   AST_LOW_LEN:    assert property (@(posedge clk) disable iff (!rst_n)
                      (bus_wr_n && !prev_wr) |-> (low_cnt == eff_len)); // R6
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
                      !busy |-> bus_wr_n);                            // R3
   AST_DROP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
                      pal_drop |-> ($past(pal_we) && $past(busy)));   // R7
   AST_DONE_ONCE:  assert property (@(posedge clk) disable iff (!rst_n)
                      done |=> !done);                                // R8
   AST_DONE_BUSY:  assert property (@(posedge clk) disable iff (!rst_n)
                      done |-> (!busy && $past(busy)));               // R8
   AST_RD_BUSY:    assert property (@(posedge clk) disable iff (!rst_n)
                      fm_rd_en |-> busy);                             // R1
   AST_CLR_EXCL:   assert property (@(posedge clk) disable iff (!rst_n)
                      fm_wr_en |-> (!fm_rd_en && bus_wr_n));          // R9
endmodule

bind pal_frame_streamer pfs_checker #(.COL_W(COL_W), .LEN_W(LEN_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .strobe_len (strobe_len),
   .pal_we     (pal_we),
   .pal_drop   (pal_drop),
   .fm_rd_en   (fm_rd_en),
   .fm_wr_en   (fm_wr_en),
   .bus_data   (bus_data),
   .bus_dc     (bus_dc),
   .bus_wr_n   (bus_wr_n),
   .busy       (busy),
   .done       (done)
);

// File: tb/pal_frame_streamer_bench.sv
`timescale 1ns/1ps
module pal_frame_streamer_bench;
   localparam int          H     = 4;
   localparam int          V     = 3;
   localparam int          NP    = H * V;
   localparam int          AW    = $clog2(NP);
   localparam int          LW    = 4;
   localparam logic [7:0]  FILL  = 8'hA5;
   localparam logic [15:0] CMD   = 16'h002C;

   // vector table: {strobe_len, pattern mode, base index}
   localparam int NVEC = 5;
   localparam logic [15:0] VEC [NVEC] = '{
      {4'd1, 4'd0, 8'd0},
      {4'd2, 4'd1, 8'd7},
      {4'd3, 4'd2, 8'd40},
      {4'd0, 4'd3, 8'd200},
      {4'd4, 4'd0, 8'd250}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          te = 1'b0;
   logic [LW-1:0] strobe_len = '0;
   logic          pal_we = 1'b0;
   logic [7:0]    pal_addr = '0;
   logic [15:0]   pal_wdata = '0;
   logic          pal_drop;
   logic [AW-1:0] fm_addr;
   logic          fm_rd_en;
   logic [7:0]    fm_rdata;
   logic          fm_wr_en;
   logic [7:0]    fm_wdata;
   logic [15:0]   bus_data;
   logic          bus_dc;
   logic          bus_wr_n;
   logic          busy;
   logic          done;

   always #5 clk = ~clk;

   pal_frame_streamer #(
      .H_PIX(H), .V_PIX(V), .LEN_W(LW), .FILL_IDX(FILL), .CMD_WORD(CMD)
   ) u_pal_frame_streamer (
      .clk(clk), .rst_n(rst_n), .start(start), .te(te), .strobe_len(strobe_len),
      .pal_we(pal_we), .pal_addr(pal_addr), .pal_wdata(pal_wdata), .pal_drop(pal_drop),
      .fm_addr(fm_addr), .fm_rd_en(fm_rd_en), .fm_rdata(fm_rdata),
      .fm_wr_en(fm_wr_en), .fm_wdata(fm_wdata), .bus_data(bus_data), .bus_dc(bus_dc),
      .bus_wr_n(bus_wr_n), .busy(busy), .done(done)
   );

   // frame memory model, one-cycle read latency; bench loads it through tb_we
   logic [7:0]    mem [NP];
   logic          tb_we = 1'b0;
   logic [AW-1:0] tb_wa = '0;
   logic [7:0]    tb_wd = '0;
   always @(posedge clk) begin
      if (fm_rd_en) fm_rdata <= mem[fm_addr];
      if (fm_wr_en) mem[fm_addr] <= fm_wdata;
      else if (tb_we) mem[tb_wa] <= tb_wd;
   end

   int checks = 0;
   int errors = 0;

   // bus monitor
   logic [15:0] w_data [512];
   logic        w_dc   [512];
   int          w_gap  [512];
   int          w_low  [512];
   int          nw = 0;
   int          run = 0;
   int          chg = 0;
   int          ndone = 0;
   logic        prev_wr = 1'b1;
   logic [15:0] prev_data = '0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (bus_wr_n != prev_wr) begin
            if (!bus_wr_n) begin
               w_data[nw] = bus_data;
               w_dc[nw]   = bus_dc;
               w_gap[nw]  = run;
               nw = nw + 1;
            end else if (nw > 0) begin
               w_low[nw-1] = run;
            end
            run = 1;
         end else begin
            run = run + 1;
         end
         if (bus_data != prev_data) chg = chg + 1;
         if (done) ndone = ndone + 1;
         prev_wr   = bus_wr_n;
         prev_data = bus_data;
      end
   end

   function automatic logic [15:0] palf(input logic [7:0] x);
      return {x ^ 8'h5A, ~x};
   endfunction

   function automatic logic [7:0] idxf(input logic [3:0] mode, input logic [7:0] base, input int i);
      case (mode)
         4'd0:    return base + 8'(i);
         4'd1:    return base;
         4'd2:    return base + 8'(i / 2);
         default: return (i % 2 == 1) ? ~base : base;
      endcase
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk); #1;
   endtask

   task automatic load_mem(input logic [3:0] mode, input logic [7:0] base);
      for (int i = 0; i < NP; i++) begin
         tb_we = 1'b1; tb_wa = AW'(i); tb_wd = idxf(mode, base, i);
         tick();
      end
      tb_we = 1'b0;
   endtask

   task automatic pulse_start();
      start = 1'b1; tick(); start = 1'b0;
   endtask

   task automatic pulse_te();
      te = 1'b1; repeat (4) tick(); te = 1'b0; repeat (2) tick();
   endtask

   logic [15:0] last_col = '0;

   // runs from a start already given; te is raised here
   task automatic finish_frame(input logic [LW-1:0] len, input logic [15:0] exp_col [NP],
                               input int base_w, input int base_chg, input int base_done);
      int eff;
      int exp_chg;
      logic [15:0] pv;
      int guard;
      eff = (len == 0) ? 1 : int'(len);
      check(nw == base_w, "R3", "strobes before te edge", nw - base_w, 0);
      check(busy == 1'b1, "R8", "busy before te", busy, 1);
      pulse_te();
      guard = 0;
      while (!done && guard < 4000) begin tick(); guard++; end
      check(done == 1'b1, "R8", "done seen", done, 1);
      check(busy == 1'b0, "R8", "busy low at done", busy, 0);
      check(bus_wr_n == 1'b1, "R8", "strobe high at done", bus_wr_n, 1);
      check(nw - base_w == NP + 1, "R1", "word count", nw - base_w, NP + 1);
      check(w_data[base_w] == CMD && w_dc[base_w] == 1'b0, "R4", "command word",
            {w_dc[base_w], w_data[base_w]}, {1'b0, CMD});
      exp_chg = (last_col != CMD) ? 1 : 0;
      pv = CMD;
      for (int k = 0; k < NP; k++) begin
         check(w_data[base_w+1+k] == exp_col[k], "R2", $sformatf("pixel %0d colour", k),
               w_data[base_w+1+k], exp_col[k]);
         check(w_dc[base_w+1+k] == 1'b1, "R4", "pixel dc", w_dc[base_w+1+k], 1);
         check(w_gap[base_w+1+k] == eff + 4, "R6", "high gap", w_gap[base_w+1+k], eff + 4);
         if (exp_col[k] != pv) exp_chg++;
         pv = exp_col[k];
      end
      for (int k = 0; k <= NP; k++)
         check(w_low[base_w+k] == eff, "R6", "low length", w_low[base_w+k], eff);
      check(chg - base_chg == exp_chg, "R5", "bus data changes", chg - base_chg, exp_chg);
      last_col = pv;
      tick();
      check(done == 1'b0 && ndone - base_done == 1, "R8", "done single pulse",
            ndone - base_done, 1);
   endtask

   task automatic wait_clear();
      repeat (NP + 4) tick();
   endtask

   bit finished = 1'b0;

   initial begin : watchdog
      #1_000_000;
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : main
      logic [15:0] ec [NP];
      int bw, bc, bd;
      repeat (3) tick();
      check(busy == 1'b0 && done == 1'b0, "R8", "reset busy/done", {busy, done}, 0);
      check(bus_wr_n == 1'b1, "R6", "reset strobe", bus_wr_n, 1);
      check(fm_rd_en == 1'b0 && fm_wr_en == 1'b0, "R1", "reset memory idle",
            {fm_rd_en, fm_wr_en}, 0);
      rst_n = 1'b1;
      tick();

      // R2: load colour table while idle; no drop
      for (int i = 0; i < 256; i++) begin
         pal_we = 1'b1; pal_addr = 8'(i); pal_wdata = palf(8'(i));
         tick();
         check(pal_drop == 1'b0, "R7", "drop while idle", pal_drop, 0);
      end
      pal_we = 1'b0;
      tick();

      // vector walk
      for (int v = 0; v < NVEC; v++) begin
         strobe_len = VEC[v][15:12];
         load_mem(VEC[v][11:8], VEC[v][7:0]);
         for (int k = 0; k < NP; k++) ec[k] = palf(idxf(VEC[v][11:8], VEC[v][7:0], k));
         bw = nw; bc = chg; bd = ndone;
         pulse_start();
         check(busy == 1'b1, "R8", "busy after start", busy, 1);
         repeat (20) tick();
         finish_frame(VEC[v][15:12], ec, bw, bc, bd);
         wait_clear();
         // R9: memory refilled
         for (int k = 0; k < NP; k++)
            check(mem[k] == FILL, "R9", $sformatf("cleared addr %0d", k), mem[k], FILL);
      end

      // R3: te edge before start has no effect
      strobe_len = 4'd2;
      load_mem(4'd0, 8'd90);
      for (int k = 0; k < NP; k++) ec[k] = palf(8'd90 + 8'(k));
      pulse_te();
      bw = nw; bc = chg; bd = ndone;
      pulse_start();
      repeat (30) tick();
      check(nw == bw, "R3", "early te ignored", nw - bw, 0);
      finish_frame(4'd2, ec, bw, bc, bd);
      wait_clear();

      // R7: table write during transfer is dropped
      load_mem(4'd1, 8'd33);
      for (int k = 0; k < NP; k++) ec[k] = palf(8'd33);
      bw = nw; bc = chg; bd = ndone;
      pulse_start();
      repeat (5) tick();
      pal_we = 1'b1; pal_addr = 8'd33; pal_wdata = 16'hFFFF;
      tick();
      pal_we = 1'b0;
      check(pal_drop == 1'b1, "R7", "drop pulse", pal_drop, 1);
      tick();
      check(pal_drop == 1'b0, "R7", "drop one cycle", pal_drop, 0);
      finish_frame(4'd2, ec, bw, bc, bd);

      // R10: start during clear is kept; frame then shows cleared memory
      repeat (2) tick();
      bw = nw; bc = chg; bd = ndone;
      pulse_start();
      check(busy == 1'b1, "R10", "busy on start during clear", busy, 1);
      check(fm_wr_en == 1'b1, "R10", "clear still running", fm_wr_en, 1);
      wait_clear();
      for (int k = 0; k < NP; k++)
         check(mem[k] == FILL, "R9", "cleared before pending frame", mem[k], FILL);
      for (int k = 0; k < NP; k++) ec[k] = palf(FILL);
      check(nw == bw, "R10", "no strobe before te", nw - bw, 0);
      finish_frame(4'd2, ec, bw, bc, bd);
      wait_clear();

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule